// File: doc/BRIEF.md
# Data Access Guard

The data access guard sits on a processor's data memory path and inspects every load or store address once. It first relocates the address into the current process slot: when the process-ID value has a nonzero top field and the address's top field is zero, the top field of the address is taken from the process-ID value. The relocated address is then checked for misalignment if alignment checking is on. A misaligned access raises an abort strobe and offers fault-status and fault-address data to the fault registers. Accesses that do not abort are compared against two data breakpoint addresses. A breakpoint hit raises a breakpoint strobe and offers a method-of-entry code to the debug registers.

The block takes the configuration registers as plain input vectors and keeps no architectural state of its own. One output register stage holds the result of each access, so every result appears on the cycle after the access is presented. Fault-register and method-of-entry writes are offered only while debug capture is enabled. The abort and breakpoint strobes themselves do not depend on that enable. Exception vectoring is left to the core.

Top module: `data_access_guard`

## Requirements
- R1: When `pid_i[31:25]` is nonzero and `acc_addr_i[31:25]` is zero, `addr_o` is `{pid_i[31:25], acc_addr_i[24:0]}`. Otherwise `addr_o` equals `acc_addr_i`. All results appear one clock after the access is presented.
- R2: `abort_o` pulses when `sys_ctrl_i[1]` is 1 and bits 1:0 of the address are not both zero. It stays low when `sys_ctrl_i[1]` is 0 or the address is word aligned.
- R3: On an abort with `dbg_en_i` high, `fault_we_o` is 1, `fault_status_o` is the alignment code 1 and `fault_addr_o` is the relocated address. With `dbg_en_i` low, `fault_we_o` stays 0 even though `abort_o` pulses.
- R4: Each breakpoint has a 2-bit mode: 0 never matches, 1 matches stores only, 2 matches loads and stores, 3 matches loads only. Breakpoint 0's mode is `dbcon_i[1:0]` and breakpoint 1's mode is `dbcon_i[3:2]`.
- R5: Outside masked mode, breakpoint n hits when bits 31:2 of the relocated address equal bits 31:2 of its reference register. Address bits 1:0 take no part in the compare.
- R6: When `dbcon_i[8]` is 1 (masked mode), `dbr1_i` is an inverse mask. A hit needs the address and `dbr0_i` to agree in every bit where `dbr1_i` is 0, together with breakpoint 0's mode. Breakpoint 1's mode is ignored in this mode.
- R7: An access that aborts never raises `bkpt_o`, even when a breakpoint matches it.
- R8: On a breakpoint hit `bkpt_o` pulses. When `dbg_en_i` is also high, `moe_we_o` is 1 and `moe_code_o` is 2 (data breakpoint). When `dbg_en_i` is low, `moe_we_o` stays 0.
- R9: After reset, and on every cycle that follows a cycle without an access, `out_valid_o`, `abort_o`, `fault_we_o`, `bkpt_o` and `moe_we_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_addr_i | input | 32 | Access address |
| acc_store_i | input | 1 | 1 for store, 0 for load |
| sys_ctrl_i | input | 32 | System control value; bit 1 enables alignment checking |
| pid_i | input | 32 | Process-ID value; bits 31:25 are the relocation field |
| dbr0_i | input | 32 | Breakpoint 0 reference address |
| dbr1_i | input | 32 | Breakpoint 1 reference address, or inverse mask in masked mode |
| dbcon_i | input | 32 | Breakpoint control: modes in bits 1:0 and 3:2, masked mode in bit 8 |
| dbg_en_i | input | 1 | Debug capture enable |
| out_valid_o | output | 1 | A result is on the outputs |
| addr_o | output | 32 | Relocated address |
| abort_o | output | 1 | Alignment abort strobe |
| fault_we_o | output | 1 | Write strobe for the fault registers |
| fault_status_o | output | 32 | Fault status write data |
| fault_addr_o | output | 32 | Fault address write data |
| bkpt_o | output | 1 | Data breakpoint strobe |
| moe_we_o | output | 1 | Write strobe for the method-of-entry field |
| moe_code_o | output | 3 | Method-of-entry code |

## Verification
The block has a single output stage, so a wrong decision shows at the ports on the cycle after the access that caused it. There is no stored state that could hide a fault for longer. A mode decoded into the wrong field, or a wrong compare width, shows up as a missing or spurious `bkpt_o` pulse for particular combinations of mode, load/store and low address bits. The bench therefore sweeps every mode pair in both compare styles. A broken priority between abort and breakpoint shows as both strobes high in the same cycle. A wrong debug gate shows as a write strobe without its abort or breakpoint strobe.

// File: rtl/dag_pkg.sv
package dag_pkg;

    // Per-breakpoint match mode
    typedef enum logic [1:0] {
        BM_OFF   = 2'd0,
        BM_STORE = 2'd1,
        BM_BOTH  = 2'd2,
        BM_LOAD  = 2'd3
    } bp_mode_e;

    function automatic logic mode_accepts(bp_mode_e mode, logic is_store);
        unique case (mode)
            BM_OFF:   return 1'b0;
            BM_STORE: return is_store;
            BM_BOTH:  return 1'b1;
            BM_LOAD:  return !is_store;
        endcase
    endfunction

endpackage

// File: rtl/dag_reloc.sv
module dag_reloc #(
    parameter int AW = 32,
    parameter int PW = 7
) (
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] pid_i,
    output logic [AW-1:0] addr_o
);
    localparam int LSB = AW - PW;

    logic [PW-1:0] slot;
    logic          reloc;
    logic          unused_pid;

    assign slot       = pid_i[AW-1:LSB];
    assign reloc      = (slot != '0) && (addr_i[AW-1:LSB] == '0);
    assign unused_pid = ^pid_i[LSB-1:0];

    always_comb begin
        addr_o = addr_i;
        if (reloc) addr_o[AW-1:LSB] = slot;
    end
endmodule

// File: rtl/dag_align.sv
module dag_align #(
    parameter int AW = 32,
    parameter int LOW_BITS = 2
) (
    input  logic          check_en_i,
    input  logic [AW-1:0] addr_i,
    output logic          misaligned_o
);
    assign misaligned_o = check_en_i && (addr_i[LOW_BITS-1:0] != '0);
endmodule

// File: rtl/dag_bkpt_cmp.sv
module dag_bkpt_cmp
    import dag_pkg::*;
#(
    parameter int AW = 32,
    parameter int IGN = 2
) (
    input  logic          [AW-1:0] addr_i,
    input  logic          [AW-1:0] ref_i,
    input  logic          [AW-1:0] inv_mask_i,
    input  logic                   use_mask_i,
    input  bp_mode_e               mode_i,
    input  logic                   is_store_i,
    output logic                   hit_o
);
    localparam logic [AW-1:0] WORD_CARE = {{(AW-IGN){1'b1}}, {IGN{1'b0}}};

    logic [AW-1:0] care;

    assign care  = use_mask_i ? ~inv_mask_i : WORD_CARE;
    assign hit_o = mode_accepts(mode_i, is_store_i)
                && (((addr_i ^ ref_i) & care) == '0);
endmodule

// File: rtl/data_access_guard.sv
module data_access_guard
    import dag_pkg::*;
#(
    parameter int AW            = 32,
    parameter int PID_W         = 7,
    parameter int LOW_BITS      = 2,
    parameter int ALIGN_BIT     = 1,
    parameter int MASK_BIT      = 8,
    parameter int NUM_BP        = 2,
    parameter int MOE_W         = 3,
    parameter logic [AW-1:0]    FAULT_ALIGN = 1,
    parameter logic [MOE_W-1:0] MOE_DATA_BP = 3'd2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             acc_valid_i,
    input  logic [AW-1:0]    acc_addr_i,
    input  logic             acc_store_i,
    input  logic [AW-1:0]    sys_ctrl_i,
    input  logic [AW-1:0]    pid_i,
    input  logic [AW-1:0]    dbr0_i,
    input  logic [AW-1:0]    dbr1_i,
    input  logic [AW-1:0]    dbcon_i,
    input  logic             dbg_en_i,
    output logic             out_valid_o,
    output logic [AW-1:0]    addr_o,
    output logic             abort_o,
    output logic             fault_we_o,
    output logic [AW-1:0]    fault_status_o,
    output logic [AW-1:0]    fault_addr_o,
    output logic             bkpt_o,
    output logic             moe_we_o,
    output logic [MOE_W-1:0] moe_code_o
);
    localparam int LSB = AW - PID_W;

    logic [AW-1:0]     addr_rel;
    logic              misaligned;
    logic              mask_mode;
    logic [NUM_BP-1:0] hit;
    logic [AW-1:0]     bp_ref [NUM_BP];
    logic              any_hit;
    logic              unused_cfg;

    assign mask_mode  = dbcon_i[MASK_BIT];
    assign bp_ref[0]  = dbr0_i;
    assign bp_ref[1]  = dbr1_i;
    assign unused_cfg = ^{sys_ctrl_i[AW-1:ALIGN_BIT+1], sys_ctrl_i[ALIGN_BIT-1:0],
                          dbcon_i[AW-1:MASK_BIT+1], dbcon_i[MASK_BIT-1:2*NUM_BP]};

    // Stage 1: relocation
    dag_reloc #(.AW(AW), .PW(PID_W)) i_reloc (
        .addr_i (acc_addr_i),
        .pid_i  (pid_i),
        .addr_o (addr_rel)
    );

    // Stage 2: alignment on the relocated address
    dag_align #(.AW(AW), .LOW_BITS(LOW_BITS)) i_align (
        .check_en_i   (sys_ctrl_i[ALIGN_BIT]),
        .addr_i       (addr_rel),
        .misaligned_o (misaligned)
    );

    // Stage 3: breakpoint comparators, one per reference register
    for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
        logic raw_hit;
        dag_bkpt_cmp #(.AW(AW), .IGN(LOW_BITS)) i_cmp (
            .addr_i     (addr_rel),
            .ref_i      (bp_ref[g]),
            .inv_mask_i (dbr1_i),
            .use_mask_i ((g == 0) ? mask_mode : 1'b0),
            .mode_i     (bp_mode_e'(dbcon_i[2*g+1:2*g])),
            .is_store_i (acc_store_i),
            .hit_o      (raw_hit)
        );
        if (g == 0) begin : g_primary
            assign hit[g] = raw_hit;
        end else begin : g_secondary
            assign hit[g] = raw_hit && !mask_mode;
        end
    end

    assign any_hit = |hit;

    // Result register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_valid_o    <= 1'b0;
            addr_o         <= '0;
            abort_o        <= 1'b0;
            fault_we_o     <= 1'b0;
            fault_status_o <= '0;
            fault_addr_o   <= '0;
            bkpt_o         <= 1'b0;
            moe_we_o       <= 1'b0;
            moe_code_o     <= '0;
        end else begin
            out_valid_o <= acc_valid_i;
            abort_o     <= acc_valid_i && misaligned;
            fault_we_o  <= acc_valid_i && misaligned && dbg_en_i;
            bkpt_o      <= acc_valid_i && !misaligned && any_hit;
            moe_we_o    <= acc_valid_i && !misaligned && any_hit && dbg_en_i;
            if (acc_valid_i) begin
                addr_o         <= addr_rel;
                fault_status_o <= FAULT_ALIGN;
                fault_addr_o   <= addr_rel;
                moe_code_o     <= MOE_DATA_BP;
            end
        end
    end

    p_low_addr_kept_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> addr_o[LSB-1:0] == $past(acc_addr_i[LSB-1:0]));

    p_fault_needs_abort_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_we_o |-> abort_o);

    p_fault_gated_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_we_o |-> $past(dbg_en_i));

    p_abort_blocks_bkpt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abort_o |-> !bkpt_o);

    p_moe_needs_bkpt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        moe_we_o |-> bkpt_o);

    p_quiet_when_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !out_valid_o |-> !(abort_o || fault_we_o || bkpt_o || moe_we_o));

endmodule

// File: tb/test_data_access_guard.sv
module test_data_access_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_store = 1'b0;
    logic [31:0] sys_ctrl = '0;
    logic [31:0] pid = '0;
    logic [31:0] dbr0 = '0;
    logic [31:0] dbr1 = '0;
    logic [31:0] dbcon = '0;
    logic        dbg_en = 1'b0;

    logic        out_valid, abort, fault_we, bkpt, moe_we;
    logic [31:0] addr_out, fault_status, fault_addr;
    logic [2:0]  moe_code;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    data_access_guard i_data_access_guard (
        .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid),
        .acc_addr_i(acc_addr), .acc_store_i(acc_store), .sys_ctrl_i(sys_ctrl),
        .pid_i(pid), .dbr0_i(dbr0), .dbr1_i(dbr1), .dbcon_i(dbcon),
        .dbg_en_i(dbg_en), .out_valid_o(out_valid), .addr_o(addr_out),
        .abort_o(abort), .fault_we_o(fault_we), .fault_status_o(fault_status),
        .fault_addr_o(fault_addr), .bkpt_o(bkpt), .moe_we_o(moe_we),
        .moe_code_o(moe_code)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_reloc(logic [31:0] a, logic [31:0] p);
        if (p[31:25] != 0 && a[31:25] == 0) return {p[31:25], a[24:0]};
        return a;
    endfunction

    function automatic logic m_mode(logic [1:0] m, logic st);
        return (m != 0) && (st ? (m != 3) : (m != 1));
    endfunction

    // Present one access, then compare the result one clock later
    task automatic access(logic [31:0] a, logic st, string tag);
        logic [31:0] ra;
        logic ab, h0, h1, bk;
        @(negedge clk);
        acc_addr = a; acc_store = st; acc_valid = 1'b1;
        ra = m_reloc(a, pid);
        ab = sys_ctrl[1] && (ra[1:0] != 0);
        if (dbcon[8]) begin
            h0 = m_mode(dbcon[1:0], st) && ((ra & ~dbr1) == (dbr0 & ~dbr1));
            h1 = 1'b0;
        end else begin
            h0 = m_mode(dbcon[1:0], st) && (ra[31:2] == dbr0[31:2]);
            h1 = m_mode(dbcon[3:2], st) && (ra[31:2] == dbr1[31:2]);
        end
        bk = !ab && (h0 || h1);
        @(negedge clk);
        acc_valid = 1'b0;
        check("R1", "addr_o", addr_out, ra);
        check("R2", "abort_o", {31'd0, abort}, {31'd0, ab});
        check("R3", "fault_we_o", {31'd0, fault_we}, {31'd0, ab && dbg_en});
        if (ab && dbg_en) begin
            check("R3", "fault_status_o", fault_status, 32'd1);
            check("R3", "fault_addr_o", fault_addr, ra);
        end
        check(tag, "bkpt_o", {31'd0, bkpt}, {31'd0, bk});
        check("R8", "moe_we_o", {31'd0, moe_we}, {31'd0, bk && dbg_en});
        if (bk && dbg_en) check("R8", "moe_code_o", {29'd0, moe_code}, 32'd2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] pids [4];
        logic [31:0] rel_addrs [3];
        logic [31:0] bp_addrs [6];
        pids[0] = 32'h0000_0000; pids[1] = 32'hFE00_0000;
        pids[2] = 32'h0200_0000; pids[3] = 32'h01FF_FFFF;
        rel_addrs[0] = 32'h0000_1234; rel_addrs[1] = 32'h0200_1234;
        rel_addrs[2] = 32'h01FF_FFFC;
        bp_addrs[0] = 32'h4000_1000; bp_addrs[1] = 32'h4000_1003;
        bp_addrs[2] = 32'h4000_10A7; bp_addrs[3] = 32'h0000_00FD;
        bp_addrs[4] = 32'h0000_00FC; bp_addrs[5] = 32'h5000_1000;

        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", "out_valid_o at reset", {31'd0, out_valid}, 32'd0);
        check("R9", "strobes at reset", {28'd0, abort, fault_we, bkpt, moe_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "strobes idle", {27'd0, out_valid, abort, fault_we, bkpt, moe_we}, 32'd0);

        // R1: relocation sweep
        for (int p = 0; p < 4; p++)
            for (int a = 0; a < 3; a++) begin
                pid = pids[p];
                access(rel_addrs[a], 1'b0, "R1");
            end
        pid = 32'h0;

        // R2 R3 R7: alignment sweep with a breakpoint that matches every access
        dbr0 = 32'h0000_8000; dbcon = 32'h2;
        for (int lo = 0; lo < 4; lo++)
            for (int en = 0; en < 2; en++)
                for (int dg = 0; dg < 2; dg++)
                    for (int st = 0; st < 2; st++) begin
                        sys_ctrl = en[0] ? 32'h2 : 32'hFFFF_FFFD;
                        dbg_en = dg[0];
                        access(32'h0000_8000 | lo, st[0], "R7");
                    end
        sys_ctrl = 32'h0;

        // R4 R5 R6 R8: breakpoint sweep over modes, compare styles and addresses
        dbr0 = 32'h4000_1000; dbr1 = 32'h0000_00FF;
        for (int mk = 0; mk < 2; mk++)
            for (int e0 = 0; e0 < 4; e0++)
                for (int e1 = 0; e1 < 4; e1++)
                    for (int st = 0; st < 2; st++)
                        for (int a = 0; a < 6; a++) begin
                            dbcon = (mk[0] ? 32'h100 : 32'h0) | (e1 << 2) | e0;
                            dbg_en = (e0 + e1 + a) % 2 == 0;
                            if (mk[0])
                                access(bp_addrs[a], st[0], "R6");
                            else if (bp_addrs[a][1:0] != 0)
                                access(bp_addrs[a], st[0], "R5");
                            else
                                access(bp_addrs[a], st[0], "R4");
                        end

        @(negedge clk);
        check("R9", "strobes after idle cycle", {27'd0, out_valid, abort, fault_we, bkpt, moe_we}, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule